// File: doc/BRIEF.md
# Biresidue Arithmetic Error Corrector

This block protects a 12-bit word against arithmetic faults, such as a carry that went wrong inside an adder, rather than against plain bit flips. On the encode side it adds two check fields to each data word: the residue of the word modulo 7 and the residue of the word modulo 15. Both moduli have the form 2^k − 1, and they are relatively prime. A fault that adds or subtracts one power of two to a word can turn many bits at once. The two residues still locate such a fault exactly.

The check side takes a coded word that may have been corrupted. It recomputes both residues of the data part and subtracts the stored check fields. The resulting syndrome pair is zero for a clean word. For each of the 24 errors of the form ±2^i with i from 0 to 11, the syndrome pair is a distinct nonzero value. The block undoes a matched error, reports any other syndrome as uncorrectable, and passes the received data through unchanged in that case. The data width equals the product of the two check widths (3 × 4), because the syndrome pairs begin to repeat at bit 12.

Both ports are single-cycle pipelines. A valid strobe on the input produces a registered result with its own valid one clock later.

Top module: `biresidue_corrector`

## Requirements
- R1: One cycle after `encValid` is high, `encOutValid` is high and `encOutData` equals the input word. `encCheckA` equals the word modulo 7 as a 3-bit unsigned value, and `encCheckB` equals the word modulo 15 as a 4-bit unsigned value. Without a strobe, `encOutValid` is low on the next cycle.
- R2: One cycle after `chkValid` is high, `outValid` is high. Without a strobe, `outValid` is low on the next cycle.
- R3: The syndrome pair is ((data mod 7) − check7) mod 7 and ((data mod 15) − check15) mod 15. A check7 field of 7 counts as 0. When both syndromes are zero, `outData` equals the received data and both flags are low.
- R4: A syndrome of (2^(i mod 3), 2^(i mod 4)) with i in 0..11 marks an error of +2^i. The block subtracts 2^i from the data and raises `outCorrected`.
- R5: A syndrome of (7 − 2^(i mod 3), 15 − 2^(i mod 4)) marks an error of −2^i. The block adds 2^i to the data and raises `outCorrected`.
- R6: Every single error of ±2^i (i = 0..11) applied to any encoded word, with the result still inside 0..4095, is restored exactly to the original word.
- R7: A nonzero syndrome pair that matches none of the 24 entries raises `outUncorrectable`, keeps `outCorrected` low, and passes the received data through unchanged.
- R8: A matched correction whose result would fall below 0 or above 4095 is not applied. The block raises `outUncorrectable` and passes the received data through unchanged.
- R9: An error made of two terms ±2^i ± 2^j (i ≠ j) that stays in range never yields both flags low.
- R10: `outCorrected` and `outUncorrectable` are never high in the same valid result.
- R11: After reset, `encOutValid`, `outValid`, `outCorrected` and `outUncorrectable` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encValid | input | 1 | Encode request strobe |
| encData | input | 12 | Word to encode |
| encOutValid | output | 1 | Encode result valid |
| encOutData | output | 12 | Encoded data part |
| encCheckA | output | 3 | Check field, word modulo 7 |
| encCheckB | output | 4 | Check field, word modulo 15 |
| chkValid | input | 1 | Check request strobe |
| chkData | input | 12 | Received data part |
| chkCheckA | input | 3 | Received modulo-7 check field |
| chkCheckB | input | 4 | Received modulo-15 check field |
| outValid | output | 1 | Check result valid |
| outData | output | 12 | Corrected or passed-through data |
| outCorrected | output | 1 | A single arithmetic error was removed |
| outUncorrectable | output | 1 | Nonzero syndrome that could not be corrected |

## Verification
The checker is tried with four kinds of input.

- Clean codewords from random words and the extremes 0 and 4095 show that a zero syndrome passes the data through untouched.
- Every ±2^i error on several random words separates the 24 syndrome entries from one another, and the sign of each, because only exact recovery of the original word passes.
- Random two-term errors show that a heavier error is never mistaken for a clean word.
- Random check fields paired with random data reach the syndromes that match no entry. Directed words at 0 and 4095 then push a matched correction out of range and so separate the range guard from the lookup.

// File: rtl/biresidue_pkg.sv
package biresidue_pkg;
  // Per-cycle load strobes from control to datapath
  typedef struct packed {
    logic encLoad;
    logic chkLoad;
  } brStrobes_t;
endpackage

// File: rtl/br_ctrl.sv
module br_ctrl
  import biresidue_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       encValid,
  input  logic       chkValid,
  output brStrobes_t strobes,
  output logic       encOutValid,
  output logic       outValid
);
  always_comb begin
    strobes.encLoad = encValid;
    strobes.chkLoad = chkValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encOutValid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      encOutValid <= encValid;
      outValid    <= chkValid;
    end
  end
endmodule

// File: rtl/br_syndrome_decode.sv
module br_syndrome_decode #(
  parameter int A_BITS = 3,
  parameter int B_BITS = 4,
  localparam int DATA_W = A_BITS * B_BITS,
  localparam int MOD_A = (1 << A_BITS) - 1,
  localparam int MOD_B = (1 << B_BITS) - 1
) (
  input  logic [A_BITS-1:0] synA,
  input  logic [B_BITS-1:0] synB,
  output logic [DATA_W-1:0] posHit,
  output logic [DATA_W-1:0] negHit
);
  // One comparator pair per bit position; the syndrome pairs are distinct,
  // so at most one bit of posHit|negHit is set, giving the magnitude 2^i.
  for (genvar i = 0; i < DATA_W; i++) begin : gPos
    localparam int EXP_A = 1 << (i % A_BITS);
    localparam int EXP_B = 1 << (i % B_BITS);
    assign posHit[i] = (synA == A_BITS'(EXP_A)) && (synB == B_BITS'(EXP_B));
    assign negHit[i] = (synA == A_BITS'(MOD_A - EXP_A)) &&
                       (synB == B_BITS'(MOD_B - EXP_B));
  end
endmodule

// File: rtl/br_datapath.sv
module br_datapath
  import biresidue_pkg::*;
#(
  parameter int A_BITS = 3,
  parameter int B_BITS = 4,
  localparam int DATA_W = A_BITS * B_BITS,
  localparam int MOD_A = (1 << A_BITS) - 1,
  localparam int MOD_B = (1 << B_BITS) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobes_t        strobes,
  input  logic [DATA_W-1:0] encData,
  input  logic [DATA_W-1:0] chkData,
  input  logic [A_BITS-1:0] chkCheckA,
  input  logic [B_BITS-1:0] chkCheckB,
  output logic [DATA_W-1:0] encOutData,
  output logic [A_BITS-1:0] encCheckA,
  output logic [B_BITS-1:0] encCheckB,
  output logic [DATA_W-1:0] outData,
  output logic              outCorrected,
  output logic              outUncorrectable
);
  function automatic logic [A_BITS-1:0] modA(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = v % DATA_W'(MOD_A);
    return r[A_BITS-1:0];
  endfunction

  function automatic logic [B_BITS-1:0] modB(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = v % DATA_W'(MOD_B);
    return r[B_BITS-1:0];
  endfunction

  // Encode residues
  logic [A_BITS-1:0] encResA;
  logic [B_BITS-1:0] encResB;
  assign encResA = modA(encData);
  assign encResB = modB(encData);

  // Syndrome formation: modular difference of recomputed and stored residues
  logic [A_BITS-1:0] rxResA, storedA, synA;
  logic [B_BITS-1:0] rxResB, storedB, synB;
  logic [A_BITS:0]   diffA;
  logic [B_BITS:0]   diffB;

  always_comb begin
    rxResA  = modA(chkData);
    rxResB  = modB(chkData);
    storedA = (chkCheckA == A_BITS'(MOD_A)) ? '0 : chkCheckA;
    storedB = (chkCheckB == B_BITS'(MOD_B)) ? '0 : chkCheckB;
    diffA   = {1'b0, rxResA} + (A_BITS+1)'(MOD_A) - {1'b0, storedA};
    diffB   = {1'b0, rxResB} + (B_BITS+1)'(MOD_B) - {1'b0, storedB};
    if (diffA >= (A_BITS+1)'(MOD_A)) diffA = diffA - (A_BITS+1)'(MOD_A);
    if (diffB >= (B_BITS+1)'(MOD_B)) diffB = diffB - (B_BITS+1)'(MOD_B);
    synA = diffA[A_BITS-1:0];
    synB = diffB[B_BITS-1:0];
  end

  logic [DATA_W-1:0] posHit, negHit;

  br_syndrome_decode #(.A_BITS(A_BITS), .B_BITS(B_BITS)) uDecode (
    .synA  (synA),
    .synB  (synB),
    .posHit(posHit),
    .negHit(negHit)
  );

  // Correction with range guard
  logic [DATA_W:0]   downSum, upSum;
  logic              anyPos, anyNeg, synZero, fixOk;
  logic [DATA_W-1:0] fixData;

  always_comb begin
    downSum = {1'b0, chkData} - {1'b0, posHit};
    upSum   = {1'b0, chkData} + {1'b0, negHit};
    anyPos  = |posHit;
    anyNeg  = |negHit;
    synZero = (synA == '0) && (synB == '0);
    fixOk   = (anyPos && !downSum[DATA_W]) || (anyNeg && !upSum[DATA_W]);
    if (!fixOk)      fixData = chkData;
    else if (anyPos) fixData = downSum[DATA_W-1:0];
    else             fixData = upSum[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encOutData <= '0;
      encCheckA  <= '0;
      encCheckB  <= '0;
    end else if (strobes.encLoad) begin
      encOutData <= encData;
      encCheckA  <= encResA;
      encCheckB  <= encResB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData          <= '0;
      outCorrected     <= 1'b0;
      outUncorrectable <= 1'b0;
    end else if (strobes.chkLoad) begin
      outData          <= fixData;
      outCorrected     <= fixOk;
      outUncorrectable <= !synZero && !fixOk;
    end
  end
endmodule

// File: rtl/biresidue_corrector.sv
module biresidue_corrector
  import biresidue_pkg::*;
#(
  parameter int A_BITS = 3,
  parameter int B_BITS = 4,
  localparam int DATA_W = A_BITS * B_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encValid,
  input  logic [DATA_W-1:0] encData,
  output logic              encOutValid,
  output logic [DATA_W-1:0] encOutData,
  output logic [A_BITS-1:0] encCheckA,
  output logic [B_BITS-1:0] encCheckB,
  input  logic              chkValid,
  input  logic [DATA_W-1:0] chkData,
  input  logic [A_BITS-1:0] chkCheckA,
  input  logic [B_BITS-1:0] chkCheckB,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outCorrected,
  output logic              outUncorrectable
);
  brStrobes_t strobes;

  br_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .encValid   (encValid),
    .chkValid   (chkValid),
    .strobes    (strobes),
    .encOutValid(encOutValid),
    .outValid   (outValid)
  );

  br_datapath #(.A_BITS(A_BITS), .B_BITS(B_BITS)) uData (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .encData         (encData),
    .chkData         (chkData),
    .chkCheckA       (chkCheckA),
    .chkCheckB       (chkCheckB),
    .encOutData      (encOutData),
    .encCheckA       (encCheckA),
    .encCheckB       (encCheckB),
    .outData         (outData),
    .outCorrected    (outCorrected),
    .outUncorrectable(outUncorrectable)
  );
endmodule

// File: rtl/biresidue_corrector_checker.sv
module biresidue_corrector_checker #(
  parameter int A_BITS = 3,
  parameter int B_BITS = 4,
  localparam int DATA_W = A_BITS * B_BITS,
  localparam int MOD_A = (1 << A_BITS) - 1,
  localparam int MOD_B = (1 << B_BITS) - 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              encValid,
  input logic [DATA_W-1:0] encData,
  input logic              encOutValid,
  input logic [DATA_W-1:0] encOutData,
  input logic [A_BITS-1:0] encCheckA,
  input logic [B_BITS-1:0] encCheckB,
  input logic              chkValid,
  input logic [DATA_W-1:0] chkData,
  input logic [A_BITS-1:0] chkCheckA,
  input logic [B_BITS-1:0] chkCheckB,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outCorrected,
  input logic              outUncorrectable
);
  AST_ENC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> encOutValid); // R1

  AST_ENC_RESIDUES: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid |-> ((32'(encOutData) % MOD_A) == 32'(encCheckA)) &&
                    ((32'(encOutData) % MOD_B) == 32'(encCheckB))); // R1

  AST_CHK_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> outValid); // R2

  AST_CLEAN_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    chkValid ##1 (outValid && !outCorrected) |-> outData == $past(chkData)); // R7

  AST_FIX_IS_CODEWORD: assert property (@(posedge clk) disable iff (!rstN)
    chkValid ##1 (outValid && outCorrected) |->
      ((32'($past(chkCheckA)) % MOD_A) == (32'(outData) % MOD_A)) &&
      ((32'($past(chkCheckB)) % MOD_B) == (32'(outData) % MOD_B))); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outCorrected && outUncorrectable)); // R10
endmodule

bind biresidue_corrector biresidue_corrector_checker #(
  .A_BITS(A_BITS), .B_BITS(B_BITS)
) uChecker (.*);

// File: tb/tb_biresidue_corrector.sv
module tb_biresidue_corrector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encValid = 1'b0;
  logic [11:0] encData = '0;
  logic        encOutValid;
  logic [11:0] encOutData;
  logic [2:0]  encCheckA;
  logic [3:0]  encCheckB;
  logic        chkValid = 1'b0;
  logic [11:0] chkData = '0;
  logic [2:0]  chkCheckA = '0;
  logic [3:0]  chkCheckB = '0;
  logic        outValid;
  logic [11:0] outData;
  logic        outCorrected;
  logic        outUncorrectable;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  biresidue_corrector dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Reference decoder built from the requirement text
  task automatic model(input int d, input int ca, input int cb,
                       output int ed, output bit ec, output bit eu);
    int sa, sb, cand;
    bit found;
    sa = ((d % 7) - (ca % 7) + 7) % 7;
    sb = ((d % 15) - (cb % 15) + 15) % 15;
    ed = d; ec = 0; eu = 0; found = 0; cand = 0;
    if (sa == 0 && sb == 0) return;
    for (int i = 0; i < 12; i++) begin
      int pa, pb;
      pa = 1 << (i % 3);
      pb = 1 << (i % 4);
      if (sa == pa && sb == pb) begin found = 1; cand = d - (1 << i); end
      if (sa == 7 - pa && sb == 15 - pb) begin found = 1; cand = d + (1 << i); end
    end
    if (found && cand >= 0 && cand < 4096) begin ed = cand; ec = 1; end
    else eu = 1;
  endtask

  task automatic doCheck(input int d, input int ca, input int cb);
    @(negedge clk);
    chkValid = 1'b1; chkData = 12'(d); chkCheckA = 3'(ca); chkCheckB = 4'(cb);
    @(negedge clk);
    chkValid = 1'b0;
  endtask

  task automatic checkModel(input int d, input int ca, input int cb, input string req);
    int ed; bit ec, eu;
    model(d, ca, cb, ed, ec, eu);
    doCheck(d, ca, cb);
    check(outValid == 1'b1, req, int'(outValid), 1);
    check(int'(outData) == ed, req, int'(outData), ed);
    check(outCorrected == ec, req, int'(outCorrected), int'(ec));
    check(outUncorrectable == eu, req, int'(outUncorrectable), int'(eu));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int words[8];
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(encOutValid == 0, "R11", int'(encOutValid), 0);
    check(outValid == 0, "R11", int'(outValid), 0);
    check(outCorrected == 0, "R11", int'(outCorrected), 0);
    check(outUncorrectable == 0, "R11", int'(outUncorrectable), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 encoding
    for (int k = 0; k < 20; k++) begin
      int w;
      w = (k == 0) ? 0 : (k == 1) ? 4095 : int'($urandom % 4096);
      encValid = 1'b1; encData = 12'(w);
      @(negedge clk);
      encValid = 1'b0;
      check(encOutValid == 1, "R1", int'(encOutValid), 1);
      check(int'(encOutData) == w, "R1", int'(encOutData), w);
      check(int'(encCheckA) == w % 7, "R1", int'(encCheckA), w % 7);
      check(int'(encCheckB) == w % 15, "R1", int'(encCheckB), w % 15);
    end
    @(negedge clk);
    check(encOutValid == 0, "R1", int'(encOutValid), 0);

    // R3 clean words
    words[0] = 0; words[1] = 4095;
    for (int k = 2; k < 8; k++) words[k] = int'($urandom % 4096);
    for (int k = 0; k < 8; k++) begin
      doCheck(words[k], words[k] % 7, words[k] % 15);
      check(outValid == 1, "R2", int'(outValid), 1);
      check(int'(outData) == words[k], "R3", int'(outData), words[k]);
      check(!outCorrected && !outUncorrectable, "R3",
            int'({outCorrected, outUncorrectable}), 0);
    end
    @(negedge clk);
    check(outValid == 0, "R2", int'(outValid), 0);
    // check7 field of 7 counts as 0
    doCheck(14, 7, 14);
    check(!outCorrected && !outUncorrectable && outData == 14, "R3",
          int'(outData), 14);

    // R4 R5 R6 exhaustive single errors
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 12; i++) begin
        for (int s = 0; s < 2; s++) begin
          int x, r;
          x = words[k];
          r = (s == 0) ? x + (1 << i) : x - (1 << i);
          if (r >= 0 && r < 4096) begin
            doCheck(r, x % 7, x % 15);
            check(int'(outData) == x, (s == 0) ? "R4" : "R5", int'(outData), x);
            check(outCorrected == 1 && outUncorrectable == 0, "R6",
                  int'({outCorrected, outUncorrectable}), 2);
          end
        end
      end
    end

    // R9 two-term errors
    for (int k = 0; k < 200; k++) begin
      int x, i, j, e, r;
      x = int'($urandom % 4096);
      i = int'($urandom % 12);
      j = (i + 1 + int'($urandom % 11)) % 12;
      e = (($urandom % 2) ? (1 << i) : -(1 << i)) + (($urandom % 2) ? (1 << j) : -(1 << j));
      r = x + e;
      if (r >= 0 && r < 4096 && e != 0) begin
        doCheck(r, x % 7, x % 15);
        check(outCorrected || outUncorrectable, "R9",
              int'({outCorrected, outUncorrectable}), 1);
        check(!(outCorrected && outUncorrectable), "R10",
              int'({outCorrected, outUncorrectable}), 1);
      end
    end

    // R7 random check fields, compared against the reference decoder
    for (int k = 0; k < 150; k++)
      checkModel(int'($urandom % 4096), int'($urandom % 8), int'($urandom % 16), "R7");
    // directed unmatched syndrome (0,1): data 0, check7 0, check15 14
    checkModel(0, 0, 14, "R7");
    check(outUncorrectable == 1 && int'(outData) == 0, "R7", int'(outUncorrectable), 1);

    // R8 out-of-range corrections
    doCheck(0, 6, 14);       // syndrome (1,1) -> would subtract 1 from 0
    check(outUncorrectable == 1 && outCorrected == 0, "R8",
          int'({outCorrected, outUncorrectable}), 1);
    check(int'(outData) == 0, "R8", int'(outData), 0);
    doCheck(4095, 1, 1);     // syndrome (6,14) -> would add 1 to 4095
    check(outUncorrectable == 1 && outCorrected == 0, "R8",
          int'({outCorrected, outUncorrectable}), 1);
    check(int'(outData) == 4095, "R8", int'(outData), 4095);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule